// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Transmit Generator

This block produces the serial transmit stream of a 2048 kbit/s E1 link built on the 16-frame CRC-4 multiframe. Every clock carries one line bit. The frames are 256 bits long. The first eight bits of each frame are timeslot 0, and the block fills them itself. It writes the frame alignment word into even frames. It writes the fixed bit, the remote-alarm bit and the national spare bits into odd frames. Bit 1 of each frame carries one of three things: the multiframe alignment pattern, a CRC-4 check bit, or an E bit. All other bits come from the `pay_in` input, so timeslots 1 to 31 pass through unchanged.

The CRC-4 remainder is computed over each half of the multiframe, which is 8 frames or 2048 bits. It uses the generator x^4 + x + 1, and the check-bit positions count as zero. The remainder is sent in the next half. Two E bits report back whether the local receiver found a CRC error in each received half. The E bits and the A bit can each follow a register value or be driven automatically.

Two registered one-cycle strobes mark where frames and multiframes begin. The upstream payload source uses them to stay aligned with the output.

Top module: `e1_crc4_txgen`

## Requirements
- R1: In even frames, bits 2..8 on the line are 0,0,1,1,0,1,1, sent in that order.
- R2: In odd frames, bit 2 is 1. Bit 3 is the A bit. The A bit equals `rx_loss` when `a_auto`=1 and equals `a_man` when `a_auto`=0.
- R3: In odd frames, bits 4..8 carry `sa_bits[0]`..`sa_bits[4]` in that order.
- R4: Bit 1 of frames 1, 3, 5, 7, 9 and 11 carries 0, 0, 1, 0, 1, 1 in that order.
- R5: Bit 1 of frames 0, 2, 4, 6 carries C1..C4 of the half ending with frame 15 of the previous multiframe. Bit 1 of frames 8, 10, 12, 14 carries C1..C4 of the half formed by frames 0..7. In the first half after reset, C1..C4 are all 0.
- R6: C1..C4 are the remainder of (half-multiframe bits × x^4) divided by x^4+x+1. The bits are taken in line order, first bit highest degree, with the C-bit positions set to 0. C1 is the x^3 coefficient.
- R7: Bit 1 of frame 13 is E1 and carries the status of received half I (`rx_rep_smf`=0). Bit 1 of frame 15 is E2 and carries the status of half II (`rx_rep_smf`=1). When `e_auto`=1, an E bit is 0 if a report with `rx_rep`=1 and `rx_rep_bad`=1 arrived for that half since its last transmission, and 1 otherwise. A report in the same cycle as the transmission counts toward the next one. When `e_auto`=0, E1 is `e_man[0]` and E2 is `e_man[1]`.
- R8: Line bits 9..256 of each frame equal the `pay_in` value sampled one cycle earlier. `pay_in` has no effect on bits 1..8.
- R9: Each line bit appears one cycle after its position is reached. `fr_stb` is high for exactly one cycle, alongside bit 1 of every frame. `mf_stb` is high only alongside bit 1 of frame 0.
- R10: While `rst_n` is low, `line_out`=1 and both strobes are 0. The first bit after reset is bit 1 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pay_in | input | 1 | Payload bit for the current position |
| a_auto | input | 1 | A bit follows `rx_loss` when 1 |
| a_man | input | 1 | A bit value when `a_auto`=0 |
| rx_loss | input | 1 | Local receiver alarm used for the automatic A bit |
| sa_bits | input | 5 | National spare bits Sa4..Sa8 (index 0 = Sa4) |
| e_auto | input | 1 | E bits follow receiver reports when 1 |
| e_man | input | 2 | E bit values when `e_auto`=0 (index 0 = E1) |
| rx_rep | input | 1 | Receiver reports a checked half this cycle |
| rx_rep_smf | input | 1 | Half of that report (0 = I, 1 = II) |
| rx_rep_bad | input | 1 | That half failed its CRC |
| line_out | output | 1 | Serial line bit |
| fr_stb | output | 1 | One-cycle pulse with bit 1 of each frame |
| mf_stb | output | 1 | One-cycle pulse with bit 1 of frame 0 |

## Verification
The block decides every output in the cycle its position counter points at a bit, and registers it. The result is visible exactly one cycle after the inputs that shaped it were sampled. The reference model steps once per clock on the same sampled inputs and predicts the next cycle's outputs. It compares them at the following falling edge, so the one-cycle latency holds for all bits, strobes and the reset state.

Two results are deferred. CRC check bits are due in the half after the one they cover, so the model keeps the whole previous half and divides it at that half's final bit. An error report shows up in the next E-bit slot of its half, up to a full multiframe later. The model holds it as a pending flag and applies the same same-cycle rule.

// File: rtl/e1tx_pkg.sv
// Shared constants and types for the E1 CRC-4 multiframe transmit generator.
// Assumes a 256-bit frame and a 16-frame multiframe with 8-bit timeslot 0.
package e1tx_pkg;
    localparam int TS0_BITS = 8;
    localparam int CRC_W    = 4;
    localparam logic [6:0] FAS_WORD  = 7'b0011011;  // bits 2..8, MSB first
    localparam logic [5:0] MFAS_WORD = 6'b001011;   // frames 1..11, MSB first
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011; // x^4 + x + 1, low terms

    typedef enum logic [2:0] {
        SLOT_PAY,
        SLOT_CRC,
        SLOT_FAS,
        SLOT_MFAS,
        SLOT_EBIT,
        SLOT_FIX,
        SLOT_ALARM,
        SLOT_SPARE
    } slot_e;
endpackage

// File: rtl/e1tx_pos_cnt.sv
// Position counter: bit index within the frame and frame index within the
// multiframe. Also flags the last bit of each 8-frame half.
// Assumes MF_FRAMES is a power of two, at least 4.
module e1tx_pos_cnt #(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [BW-1:0] bit_idx,
    output logic [FW-1:0] frm_idx,
    output logic          smf_end
);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] LAST_FRM = FW'(MF_FRAMES - 1);

    logic [BW-1:0] bit_q;
    logic [FW-1:0] frm_q;

    // Advance one bit per clock, wrapping frame and multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            frm_q <= '0;
        end else if (bit_q == LAST_BIT) begin
            bit_q <= '0;
            frm_q <= (frm_q == LAST_FRM) ? '0 : frm_q + 1'b1;
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Last bit of a half: final bit of frame 7 or frame 15.
    always_comb begin
        smf_end = (bit_q == LAST_BIT) && (&frm_q[FW-2:0]);
    end

    assign bit_idx = bit_q;
    assign frm_idx = frm_q;
endmodule

// File: rtl/e1tx_crc4.sv
// Serial CRC-4 over one half-multiframe. Check-bit positions are fed as
// zero. At the end of the half the remainder moves to a hold register that
// the next half transmits. Assumes bits arrive highest degree first.
module e1tx_crc4
    import e1tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             zero_slot,
    input  logic             smf_end,
    output logic [CRC_W-1:0] crc_hold
);
    logic [CRC_W-1:0] acc_q;
    logic [CRC_W-1:0] acc_nx;
    logic [CRC_W-1:0] hold_q;
    logic             fb;

    // Next remainder after taking in one message bit.
    always_comb begin
        fb     = (din & ~zero_slot) ^ acc_q[CRC_W-1];
        acc_nx = {acc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    // Accumulate, or at the end of a half publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            hold_q <= '0;
        end else if (smf_end) begin
            acc_q  <= '0;
            hold_q <= acc_nx;
        end else begin
            acc_q  <= acc_nx;
        end
    end

    assign crc_hold = hold_q;
endmodule

// File: rtl/e1tx_ts0_map.sv
// Picks the source of the current line bit from the position. Bits 1..8
// are timeslot 0 overhead; all other bits come from the payload.
// Assumes a 16-frame multiframe (frame pairs 0..7) and four check bits.
module e1tx_ts0_map
    import e1tx_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic [BW-1:0]    bit_idx,
    input  logic [FW-1:0]    frm_idx,
    input  logic             pay_in,
    input  logic [CRC_W-1:0] crc_hold,
    input  logic             a_bit,
    input  logic [4:0]       sa_bits,
    input  logic [1:0]       e_bits,
    output slot_e            slot,
    output logic             bit_val
);
    logic [2:0]    tsb;
    logic [FW-2:0] pair;

    // Decode the slot kind and select its bit value.
    always_comb begin
        tsb     = bit_idx[2:0];
        pair    = frm_idx[FW-1:1];
        slot    = SLOT_PAY;
        bit_val = pay_in;
        if (bit_idx < BW'(TS0_BITS)) begin
            if (!frm_idx[0]) begin
                if (tsb == 3'd0) begin
                    slot    = SLOT_CRC;
                    bit_val = crc_hold[2'd3 - pair[1:0]];
                end else begin
                    slot    = SLOT_FAS;
                    bit_val = FAS_WORD[3'd7 - tsb];
                end
            end else begin
                case (tsb)
                    3'd0: begin
                        if (pair < (FW-1)'(6)) begin
                            slot    = SLOT_MFAS;
                            bit_val = MFAS_WORD[3'd5 - pair[2:0]];
                        end else begin
                            slot    = SLOT_EBIT;
                            bit_val = e_bits[pair[0]];
                        end
                    end
                    3'd1: begin
                        slot    = SLOT_FIX;
                        bit_val = 1'b1;
                    end
                    3'd2: begin
                        slot    = SLOT_ALARM;
                        bit_val = a_bit;
                    end
                    default: begin
                        slot    = SLOT_SPARE;
                        bit_val = sa_bits[tsb - 3'd3];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/e1_crc4_txgen.sv
// E1 CRC-4 multiframe transmit generator. Builds timeslot 0 for each frame,
// passes payload for the other bits and registers the serial output with
// frame and multiframe strobes. One line bit per clock.
// Assumes FRAME_BITS = 256 and MF_FRAMES = 16 for the standard format.
module e1_crc4_txgen
    import e1tx_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pay_in,
    input  logic       a_auto,
    input  logic       a_man,
    input  logic       rx_loss,
    input  logic [4:0] sa_bits,
    input  logic       e_auto,
    input  logic [1:0] e_man,
    input  logic       rx_rep,
    input  logic       rx_rep_smf,
    input  logic       rx_rep_bad,
    output logic       line_out,
    output logic       fr_stb,
    output logic       mf_stb
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = $clog2(MF_FRAMES);

    logic [BW-1:0]    bit_idx;
    logic [FW-1:0]    frm_idx;
    logic             smf_end;
    logic [CRC_W-1:0] crc_hold;
    slot_e            slot;
    logic             nxt_bit;
    logic             a_bit;
    logic [1:0]       e_bits;
    logic [1:0]       e_flag_q;
    logic             e_slot;
    logic             line_q, fr_q, mf_q;

    e1tx_pos_cnt #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) i_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_idx (bit_idx),
        .frm_idx (frm_idx),
        .smf_end (smf_end)
    );

    e1tx_ts0_map #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) i_map (
        .bit_idx  (bit_idx),
        .frm_idx  (frm_idx),
        .pay_in   (pay_in),
        .crc_hold (crc_hold),
        .a_bit    (a_bit),
        .sa_bits  (sa_bits),
        .e_bits   (e_bits),
        .slot     (slot),
        .bit_val  (nxt_bit)
    );

    e1tx_crc4 i_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (nxt_bit),
        .zero_slot (slot == SLOT_CRC),
        .smf_end   (smf_end),
        .crc_hold  (crc_hold)
    );

    // Select register or automatic sources for the A and E bits.
    always_comb begin
        a_bit  = a_auto ? rx_loss : a_man;
        e_bits = e_auto ? ~e_flag_q : e_man;
        e_slot = (slot == SLOT_EBIT);
    end

    // Pending error flag per received half: cleared when sent, set on report.
    for (genvar s = 0; s < 2; s++) begin : g_eflag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_flag_q[s] <= 1'b0;
            end else begin
                e_flag_q[s] <= (e_flag_q[s] & ~(e_slot && (frm_idx[1] == 1'(s))))
                             | (rx_rep && rx_rep_bad && (rx_rep_smf == 1'(s)));
            end
        end
    end

    // Register the line bit and the strobes for the current position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
            fr_q   <= 1'b0;
            mf_q   <= 1'b0;
        end else begin
            line_q <= nxt_bit;
            fr_q   <= (bit_idx == '0);
            mf_q   <= (bit_idx == '0) && (frm_idx == '0);
        end
    end

    assign line_out = line_q;
    assign fr_stb   = fr_q;
    assign mf_stb   = mf_q;
endmodule

// File: rtl/e1tx_chk.sv
// Checker for the transmit generator. It rebuilds the position from the
// output strobes alone and checks the fixed overhead bits and the strobe
// cadence. Assumes the default frame and multiframe sizes.
module e1tx_chk #(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16
) (
    input logic clk,
    input logic rst_n,
    input logic line_out,
    input logic fr_stb,
    input logic mf_stb
);
    localparam logic [6:0] FAS_CHK  = 7'b0011011;
    localparam logic [5:0] MFAS_CHK = 6'b001011;

    int   bq, fq, since;
    logic seen_mf, seen_fr;
    int   cur_b, cur_f;
    logic trk, exp_fas, exp_mfas;

    // Position of the bit now on the line, derived from the strobes.
    always_comb begin
        cur_b    = fr_stb ? 0 : bq + 1;
        cur_f    = mf_stb ? 0 : (fr_stb ? fq + 1 : fq);
        trk      = seen_mf | mf_stb;
        exp_fas  = (cur_b >= 1 && cur_b <= 7) ? FAS_CHK[7 - cur_b] : 1'b0;
        exp_mfas = (cur_f >= 1 && cur_f <= 11) ? MFAS_CHK[5 - cur_f / 2] : 1'b0;
    end

    // Track position and frame spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bq <= 0; fq <= 0; since <= 0;
            seen_mf <= 1'b0; seen_fr <= 1'b0;
        end else begin
            bq      <= (cur_b > 100000) ? 100000 : cur_b;
            fq      <= (cur_f > 100000) ? 100000 : cur_f;
            since   <= fr_stb ? 1 : ((since > 100000) ? since : since + 1);
            seen_mf <= seen_mf | mf_stb;
            seen_fr <= seen_fr | fr_stb;
        end
    end

    p_fr_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_fr && fr_stb) |-> (since == FRAME_BITS));
    p_mf_on_fr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_stb |-> fr_stb);
    p_mf_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_mf && mf_stb) |-> (fq == MF_FRAMES - 1));
    p_first_mf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> mf_stb);
    p_fas_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && cur_f[0] == 1'b0 && cur_b >= 1 && cur_b <= 7) |-> (line_out == exp_fas));
    p_fix_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && cur_f[0] == 1'b1 && cur_b == 1) |-> line_out);
    p_mfas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && cur_f[0] == 1'b1 && cur_f <= 11 && cur_b == 0) |-> (line_out == exp_mfas));
endmodule

bind e1_crc4_txgen e1tx_chk #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_out (line_out),
    .fr_stb   (fr_stb),
    .mf_stb   (mf_stb)
);

// File: tb/test_e1_crc4_txgen.sv
// Bench: a behavioural reference model steps on the same inputs each clock
// and predicts the next outputs; the outputs are compared at falling edges.
module test_e1_crc4_txgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pay_in = 1'b0, a_auto = 1'b0, a_man = 1'b0, rx_loss = 1'b0;
    logic [4:0] sa_bits = '0;
    logic       e_auto = 1'b0;
    logic [1:0] e_man = '0;
    logic       rx_rep = 1'b0, rx_rep_smf = 1'b0, rx_rep_bad = 1'b0;
    logic       line_out, fr_stb, mf_stb;

    e1_crc4_txgen i_e1_crc4_txgen (.*);

    always #2 clk = ~clk;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    int    m_bit, m_frm;
    bit    sbuf[2048];
    bit    chold[4];
    bit    eflag[2];
    bit    fresh;
    bit    exp_line = 1'b1, exp_fr = 1'b0, exp_mf = 1'b0;
    string tag = "R10";

    int fas[7]  = '{0, 0, 1, 1, 0, 1, 1};
    int mfas[6] = '{0, 0, 1, 0, 1, 1};

    task automatic chk(input string t, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, act, exp, $time);
        end
    endtask

    // Long division of the buffered half by 10011 after appending four zeros.
    task automatic divide_half();
        bit a[2052];
        for (int i = 0; i < 2048; i++) a[i] = sbuf[i];
        for (int i = 2048; i < 2052; i++) a[i] = 1'b0;
        for (int i = 0; i < 2048; i++) begin
            if (a[i]) begin
                a[i] ^= 1'b1; a[i+3] ^= 1'b1; a[i+4] ^= 1'b1;
            end
        end
        for (int k = 0; k < 4; k++) chold[k] = a[2048+k];
    endtask

    // Predict the outputs due after the coming clock edge.
    task automatic model_step();
        bit v, cz;
        cz = 1'b0;
        if (!rst_n) begin
            exp_line = 1'b1; exp_fr = 1'b0; exp_mf = 1'b0; tag = "R10";
            m_bit = 0; m_frm = 0; fresh = 1'b1;
            for (int k = 0; k < 4; k++) chold[k] = 1'b0;
            eflag[0] = 1'b0; eflag[1] = 1'b0;
            return;
        end
        v = pay_in; tag = "R8";
        if (m_bit < 8) begin
            if (m_frm % 2 == 0) begin
                if (m_bit == 0) begin
                    v = chold[(m_frm % 8) / 2]; cz = 1'b1;
                    tag = fresh ? "R5" : "R6";
                end else begin
                    v = fas[m_bit-1]; tag = "R1";
                end
            end else if (m_bit == 0) begin
                if (m_frm <= 11) begin
                    v = mfas[(m_frm-1)/2]; tag = "R4";
                end else begin
                    int s = (m_frm == 13) ? 0 : 1;
                    v = e_auto ? !eflag[s] : e_man[s]; tag = "R7";
                    eflag[s] = 1'b0;
                end
            end else if (m_bit == 1) begin
                v = 1'b1; tag = "R2";
            end else if (m_bit == 2) begin
                v = a_auto ? rx_loss : a_man; tag = "R2";
            end else begin
                v = sa_bits[m_bit-3]; tag = "R3";
            end
        end
        if (rx_rep && rx_rep_bad) eflag[rx_rep_smf] = 1'b1;
        sbuf[(m_frm % 8) * 256 + m_bit] = cz ? 1'b0 : v;
        if (m_bit == 255 && m_frm % 8 == 7) begin
            divide_half(); fresh = 1'b0;
        end
        exp_line = v;
        exp_fr = (m_bit == 0);
        exp_mf = (m_bit == 0 && m_frm == 0);
        m_bit++;
        if (m_bit == 256) begin
            m_bit = 0;
            m_frm = (m_frm + 1) % 16;
        end
    endtask

    // Stimulus, comparison and model stepping, all at falling edges.
    initial begin
        for (int n = 0; n < 36000; n++) begin
            @(negedge clk);
            chk((tag == "R10") ? "R10" : tag, line_out, exp_line, "line_out");
            chk((tag == "R10") ? "R10" : "R9", fr_stb, exp_fr, "fr_stb");
            chk((tag == "R10") ? "R10" : "R9", mf_stb, exp_mf, "mf_stb");
            rst_n = !(n < 4 || (n >= 20000 && n < 20003));
            if (n < 9000) begin
                a_auto = 1'b0; a_man = 1'b1; e_auto = 1'b0; e_man = 2'b01;
                sa_bits = 5'b10110;
                pay_in = (n < 3000) ? 1'b1 : 1'($urandom);
            end else begin
                a_auto = 1'b1; e_auto = 1'b1;
                if (n % 700 == 0) rx_loss = !rx_loss;
                sa_bits = (n < 20000) ? 5'b01001 : 5'b11100;
                pay_in = (n >= 24000 && n < 25000) ? 1'b0 : 1'($urandom);
            end
            if (n >= 9000 && n % 311 == 0) begin
                rx_rep = 1'b1; rx_rep_smf = 1'($urandom); rx_rep_bad = 1'($urandom);
            end else if (n % 4096 == 3328 || n % 4096 == 3840) begin
                rx_rep = 1'b1; rx_rep_smf = 1'b1; rx_rep_bad = 1'b1;
            end else begin
                rx_rep = 1'b0; rx_rep_bad = 1'($urandom);
            end
            model_step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule